// File: doc/BRIEF.md
# Flush-to-Zero Underflow Result Stage

This block sits after the rounder of a single-precision floating-point datapath. Each accepted operation brings a sign, a biased exponent, a fraction, and two indications from the rounder: whether the result is tiny and whether it is inexact. Two bits of a 32-bit control word are also applied. The block then settles the final outcome one clock later. There are three possible outcomes. A gradual-underflow result (a denormal) passes through unchanged. A flushed zero takes the sign of the true result. A trap request goes to the exception logic.

When the underflow exception is unmasked, it wins over flush-to-zero. A tiny result then always asks for a trap, no matter how the flush bit is set. A trapped operation produces no valid result and no flag pulse. Each valid result carries one-cycle precision and underflow flag pulses. These pulses are also gathered into sticky status bits, which stay set until the clear input is pulsed.

Top module: `ftz_underflow_stage`

## Requirements
- R1: The flush enable is bit 15 of `ctrl_word` and the underflow mask is bit 11 (1 = masked). No other bit of `ctrl_word` changes any output.
- R2: A result with `in_tiny` low is output one cycle after `in_valid` as `{sign, exp, frac}` (sign in bit 31, exponent in bits 30:23, fraction in bits 22:0), with `out_valid` high. Its precision pulse equals `in_inexact` and its underflow pulse is 0. This holds for normals, infinities and NaNs.
- R3: A tiny result that is masked with flush enabled comes out one cycle later as a zero. Bit 31 is the input sign and bits 30:0 are 0.
- R4: Such a flushed result raises both the precision pulse and the underflow pulse, even when `in_inexact` is low.
- R5: A tiny result that is masked with flush disabled passes through unchanged. Both its precision and underflow pulses equal `in_inexact`.
- R6: A tiny result that is unmasked raises `trap_req` for one cycle, one cycle after `in_valid`, whatever the flush bit. In that cycle `out_valid` and both flag pulses stay low.
- R7: The flag pulses are high only in a cycle where `out_valid` is high.
- R8: The sticky bits OR in every flag pulse one cycle after the pulse and hold until `sticky_clr` is high at a clock edge. A pulse that arrives in the same cycle as the clear is kept.
- R9: While `rst_n` is low, `out_valid`, `trap_req`, both flag pulses and both sticky bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | An operation is presented this cycle |
| in_sign | input | 1 | Sign of the rounded result |
| in_exp | input | 8 | Biased exponent of the rounded result |
| in_frac | input | 23 | Fraction of the rounded result |
| in_tiny | input | 1 | The rounder found the result tiny |
| in_inexact | input | 1 | The rounder found the result inexact |
| ctrl_word | input | 32 | Control word: flush enable at bit 15, underflow mask at bit 11 |
| sticky_clr | input | 1 | Clears the sticky flag bits |
| out_valid | output | 1 | The final result word is valid |
| out_word | output | 32 | Final single-precision result |
| flag_prec | output | 1 | Precision flag pulse |
| flag_unfl | output | 1 | Underflow flag pulse |
| trap_req | output | 1 | Underflow trap request |
| sticky_prec | output | 1 | Sticky precision flag |
| sticky_unfl | output | 1 | Sticky underflow flag |

## Verification
Several properties are checked on every cycle. A trap is never paired with a valid result or a flag. Flag pulses never appear without a valid result. Any flushed or pass-through result has the right word and the right flags one cycle after its input. An unmasked tiny input always produces a trap. Sticky bits never drop except after a clear. Some behaviour can only be shown by the bench's scenarios: that the other control-word bits have no effect, the exact flag values of masked denormals for each inexact setting, and the case where a clear and a new flag pulse meet in the same cycle. The bench also tests back-to-back streams, where the ordering of results against a scoreboard matters.

// File: rtl/ftz_pkg.sv
package ftz_pkg;
  typedef enum logic [1:0] {
    OUTC_PASS  = 2'd0,
    OUTC_FLUSH = 2'd1,
    OUTC_TRAP  = 2'd2
  } outcome_e;

  localparam int FLAG_PREC = 0;
  localparam int FLAG_UNFL = 1;
  localparam int NUM_FLAGS = 2;
endpackage

// File: rtl/ftz_decide.sv
module ftz_decide
  import ftz_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int WORD_W = 1 + EXP_W + FRAC_W
) (
  input  logic                 sign_i,
  input  logic [EXP_W-1:0]     exp_i,
  input  logic [FRAC_W-1:0]    frac_i,
  input  logic                 tiny_i,
  input  logic                 inexact_i,
  input  logic                 flush_en_i,
  input  logic                 unfl_masked_i,
  output outcome_e             outcome_o,
  output logic [WORD_W-1:0]    word_o,
  output logic [NUM_FLAGS-1:0] flags_o
);
  always_comb begin
    outcome_o = OUTC_PASS;
    word_o    = {sign_i, exp_i, frac_i};
    flags_o   = '0;
    if (tiny_i && !unfl_masked_i) begin
      outcome_o = OUTC_TRAP;
    end else if (tiny_i && flush_en_i) begin
      outcome_o          = OUTC_FLUSH;
      word_o             = {sign_i, {(WORD_W-1){1'b0}}};
      flags_o[FLAG_PREC] = 1'b1;
      flags_o[FLAG_UNFL] = 1'b1;
    end else begin
      flags_o[FLAG_PREC] = inexact_i;
      flags_o[FLAG_UNFL] = tiny_i & inexact_i;
    end
  end
endmodule

// File: rtl/ftz_out_reg.sv
module ftz_out_reg
  import ftz_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 valid_i,
  input  outcome_e             outcome_i,
  input  logic [WORD_W-1:0]    word_i,
  input  logic [NUM_FLAGS-1:0] flags_i,
  output logic                 valid_o,
  output logic                 trap_o,
  output logic [WORD_W-1:0]    word_o,
  output logic [NUM_FLAGS-1:0] flags_o
);
  logic                 valid_d, trap_d, word_en;
  logic [NUM_FLAGS-1:0] flags_d;

  always_comb begin
    valid_d = valid_i && (outcome_i != OUTC_TRAP);
    trap_d  = valid_i && (outcome_i == OUTC_TRAP);
    flags_d = valid_d ? flags_i : '0;
    word_en = valid_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_o <= 1'b0;
      trap_o  <= 1'b0;
      flags_o <= '0;
    end else begin
      valid_o <= valid_d;
      trap_o  <= trap_d;
      flags_o <= flags_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_o <= '0;
    end else if (word_en) begin
      word_o <= word_i;
    end
  end
endmodule

// File: rtl/ftz_sticky.sv
module ftz_sticky #(
  parameter int NUM = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clr_i,
  input  logic [NUM-1:0] set_i,
  output logic [NUM-1:0] sticky_o
);
  for (genvar g = 0; g < NUM; g++) begin : g_bit
    logic bit_d;
    always_comb begin
      bit_d = (sticky_o[g] & ~clr_i) | set_i[g];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sticky_o[g] <= 1'b0;
      else        sticky_o[g] <= bit_d;
    end
  end
endmodule

// File: rtl/ftz_underflow_stage.sv
module ftz_underflow_stage
  import ftz_pkg::*;
#(
  parameter int EXP_W     = 8,
  parameter int FRAC_W    = 23,
  parameter int CTRL_W    = 32,
  parameter int FLUSH_BIT = 15,
  parameter int UMASK_BIT = 11,
  localparam int WORD_W   = 1 + EXP_W + FRAC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_sign,
  input  logic [EXP_W-1:0]  in_exp,
  input  logic [FRAC_W-1:0] in_frac,
  input  logic              in_tiny,
  input  logic              in_inexact,
  input  logic [CTRL_W-1:0] ctrl_word,
  input  logic              sticky_clr,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_word,
  output logic              flag_prec,
  output logic              flag_unfl,
  output logic              trap_req,
  output logic              sticky_prec,
  output logic              sticky_unfl
);
  logic                 flush_en, unfl_masked, ctrl_unused;
  outcome_e             outcome;
  logic [WORD_W-1:0]    dec_word;
  logic [NUM_FLAGS-1:0] dec_flags, pulse_flags, sticky_flags;

  assign flush_en    = ctrl_word[FLUSH_BIT];
  assign unfl_masked = ctrl_word[UMASK_BIT];
  assign ctrl_unused = ^ctrl_word;

  ftz_decide #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) decide_i (
    .sign_i        (in_sign),
    .exp_i         (in_exp),
    .frac_i        (in_frac),
    .tiny_i        (in_tiny),
    .inexact_i     (in_inexact),
    .flush_en_i    (flush_en),
    .unfl_masked_i (unfl_masked),
    .outcome_o     (outcome),
    .word_o        (dec_word),
    .flags_o       (dec_flags)
  );

  ftz_out_reg #(.WORD_W(WORD_W)) out_reg_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .valid_i   (in_valid),
    .outcome_i (outcome),
    .word_i    (dec_word),
    .flags_i   (dec_flags),
    .valid_o   (out_valid),
    .trap_o    (trap_req),
    .word_o    (out_word),
    .flags_o   (pulse_flags)
  );

  ftz_sticky #(.NUM(NUM_FLAGS)) sticky_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_i    (sticky_clr),
    .set_i    (pulse_flags),
    .sticky_o (sticky_flags)
  );

  assign flag_prec   = pulse_flags[FLAG_PREC];
  assign flag_unfl   = pulse_flags[FLAG_UNFL];
  assign sticky_prec = sticky_flags[FLAG_PREC];
  assign sticky_unfl = sticky_flags[FLAG_UNFL];
endmodule

// File: rtl/ftz_underflow_stage_chk.sv
module ftz_underflow_stage_chk #(
  parameter int EXP_W     = 8,
  parameter int FRAC_W    = 23,
  parameter int CTRL_W    = 32,
  parameter int FLUSH_BIT = 15,
  parameter int UMASK_BIT = 11,
  localparam int WORD_W   = 1 + EXP_W + FRAC_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_sign,
  input logic [EXP_W-1:0]  in_exp,
  input logic [FRAC_W-1:0] in_frac,
  input logic              in_tiny,
  input logic              in_inexact,
  input logic [CTRL_W-1:0] ctrl_word,
  input logic              sticky_clr,
  input logic              out_valid,
  input logic [WORD_W-1:0] out_word,
  input logic              flag_prec,
  input logic              flag_unfl,
  input logic              trap_req,
  input logic              sticky_prec,
  input logic              sticky_unfl
);
  logic seen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen <= 1'b0;
    else        seen <= 1'b1;
  end

  // R6
  trap_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |-> (!out_valid && !flag_prec && !flag_unfl));

  // R6
  trap_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && $past(in_valid && in_tiny && !ctrl_word[UMASK_BIT])) |-> trap_req);

  // R7
  flag_with_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_prec || flag_unfl) |-> out_valid);

  // R3
  flush_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && $past(in_valid && in_tiny && ctrl_word[UMASK_BIT] && ctrl_word[FLUSH_BIT]))
    |-> (out_valid && out_word == {$past(in_sign), {(WORD_W-1){1'b0}}}));

  // R4
  flush_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && $past(in_valid && in_tiny && ctrl_word[UMASK_BIT] && ctrl_word[FLUSH_BIT]))
    |-> (flag_prec && flag_unfl));

  // R2
  pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && $past(in_valid && !in_tiny))
    |-> (out_valid && !flag_unfl && out_word == $past({in_sign, in_exp, in_frac})
         && flag_prec == $past(in_inexact)));

  // R8
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && $past(sticky_prec && !sticky_clr)) |-> sticky_prec);

  // R8
  sticky_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && $past(flag_unfl)) |-> sticky_unfl);

  // R9
  always @(posedge clk) begin
    if (!rst_n) begin
      reset_quiet_chk: assert (!out_valid && !trap_req && !flag_prec && !flag_unfl
                               && !sticky_prec && !sticky_unfl);
    end
  end
endmodule

bind ftz_underflow_stage ftz_underflow_stage_chk #(
  .EXP_W(EXP_W), .FRAC_W(FRAC_W), .CTRL_W(CTRL_W),
  .FLUSH_BIT(FLUSH_BIT), .UMASK_BIT(UMASK_BIT)
) chk_i (.*);

// File: tb/ftz_underflow_stage_tb_top.sv
module ftz_underflow_stage_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] C_FTZ = 32'h0000_8000;
  localparam logic [31:0] C_UM  = 32'h0000_0800;

  logic        clk, rst_n, in_valid, in_sign, in_tiny, in_inexact, sticky_clr;
  logic [7:0]  in_exp;
  logic [22:0] in_frac;
  logic [31:0] ctrl_word, out_word;
  logic        out_valid, flag_prec, flag_unfl, trap_req, sticky_prec, sticky_unfl;

  ftz_underflow_stage dut_i (.*);

  typedef struct {
    logic        trap;
    logic [31:0] word;
    logic        prec;
    logic        unfl;
    string       tag;
  } exp_t;

  exp_t q[$];
  int   errors = 0;
  int   checks = 0;
  logic [1:0] exp_sticky = 2'b00;
  logic mon_on = 1'b0;

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic exp_t model(logic s, logic [7:0] e, logic [22:0] f,
                                 logic t, logic x, logic [31:0] c, string tag);
    exp_t r;
    r.tag = tag;
    r.trap = t && !c[11];
    r.word = {s, e, f};
    r.prec = x;
    r.unfl = t && x;
    if (r.trap) begin
      r.prec = 1'b0; r.unfl = 1'b0;
    end else if (t && c[15]) begin
      r.word = {s, 31'd0}; r.prec = 1'b1; r.unfl = 1'b1;
    end
    return r;
  endfunction

  task automatic send(logic s, logic [7:0] e, logic [22:0] f,
                      logic t, logic x, logic [31:0] c, string tag);
    @(posedge clk); #1;
    in_valid = 1'b1; in_sign = s; in_exp = e; in_frac = f;
    in_tiny = t; in_inexact = x; ctrl_word = c;
    q.push_back(model(s, e, f, t, x, c, tag));
  endtask

  task automatic idle(int n);
    @(posedge clk); #1;
    in_valid = 1'b0;
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check_sticky(logic [1:0] e, string tag);
    checks++;
    if ({sticky_unfl, sticky_prec} !== e) begin
      errors++;
      $display("FAIL %s sticky unfl/prec actual=%b expected=%b", tag,
               {sticky_unfl, sticky_prec}, e);
    end
  endtask

  always @(negedge clk) begin
    if (mon_on && rst_n) begin
      if (out_valid || trap_req) begin
        checks++;
        if (q.size() == 0) begin
          errors++;
          $display("FAIL R2 unexpected output actual valid=%b trap=%b expected none",
                   out_valid, trap_req);
        end else begin
          exp_t e;
          e = q.pop_front();
          if (trap_req !== e.trap || out_valid !== !e.trap ||
              (!e.trap && (out_word !== e.word || flag_prec !== e.prec || flag_unfl !== e.unfl)) ||
              (e.trap && (flag_prec || flag_unfl))) begin
            errors++;
            $display("FAIL %s actual trap=%b v=%b w=%h p=%b u=%b expected trap=%b w=%h p=%b u=%b",
                     e.tag, trap_req, out_valid, out_word, flag_prec, flag_unfl,
                     e.trap, e.word, e.prec, e.unfl);
          end
          if (!e.trap) exp_sticky = exp_sticky | {e.unfl, e.prec};
        end
      end else if (flag_prec || flag_unfl) begin
        checks++;
        errors++;
        $display("FAIL R7 flag pulse without valid actual p=%b u=%b expected 0 0",
                 flag_prec, flag_unfl);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_sign = 1'b0; in_exp = '0; in_frac = '0;
    in_tiny = 1'b0; in_inexact = 1'b0; ctrl_word = '0; sticky_clr = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    // R9 reset state
    checks++;
    if ({out_valid, trap_req, flag_prec, flag_unfl, sticky_prec, sticky_unfl} !== 6'b0) begin
      errors++;
      $display("FAIL R9 reset outputs actual=%b expected=000000",
               {out_valid, trap_req, flag_prec, flag_unfl, sticky_prec, sticky_unfl});
    end
    @(posedge clk); #1;
    rst_n = 1'b1;
    mon_on = 1'b1;

    // R2 pass-through of normals, infinity, NaN
    send(1'b0, 8'h7f, 23'h123456, 1'b0, 1'b1, C_UM | C_FTZ, "R2 normal inexact");
    send(1'b1, 8'h80, 23'h000001, 1'b0, 1'b0, C_FTZ, "R2 normal exact unmasked");
    send(1'b1, 8'hff, 23'h0, 1'b0, 1'b0, C_UM, "R2 infinity");
    send(1'b0, 8'hff, 23'h400001, 1'b0, 1'b0, 32'h0, "R2 NaN");
    idle(3);
    // R5 masked denormal, no flush
    send(1'b0, 8'h00, 23'h0abcde, 1'b1, 1'b1, C_UM, "R5 denormal inexact");
    send(1'b1, 8'h00, 23'h000010, 1'b1, 1'b0, C_UM, "R5 denormal exact");
    // R3 R4 flushed zero, sign kept, both flags even when exact
    send(1'b1, 8'h00, 23'h7fffff, 1'b1, 1'b0, C_UM | C_FTZ, "R3 R4 flush negative");
    send(1'b0, 8'h01, 23'h000000, 1'b1, 1'b1, C_UM | C_FTZ, "R3 R4 flush positive");
    // R6 unmasked traps regardless of flush
    send(1'b0, 8'h00, 23'h000123, 1'b1, 1'b1, C_FTZ, "R6 trap flush on");
    send(1'b1, 8'h00, 23'h000123, 1'b1, 1'b0, 32'h0, "R6 trap flush off");
    send(1'b0, 8'h40, 23'h000001, 1'b0, 1'b1, C_UM, "R2 after trap");
    // R1 other control bits ignored
    send(1'b1, 8'h00, 23'h055555, 1'b1, 1'b1, ~C_FTZ, "R1 noise bits masked no flush");
    send(1'b0, 8'h00, 23'h055555, 1'b1, 1'b0, 32'hFFFF_FFFF, "R1 noise bits flush");
    send(1'b1, 8'h00, 23'h055555, 1'b1, 1'b1, ~C_UM, "R1 noise bits unmasked");
    send(1'b0, 8'h12, 23'h3, 1'b0, 1'b0, 32'hFFFF_77FF, "R1 noise bits normal");
    idle(4);

    // R8 sticky accumulation
    check_sticky(exp_sticky, "R8 accumulated");
    @(posedge clk); #1; sticky_clr = 1'b1;
    @(posedge clk); #1; sticky_clr = 1'b0;
    exp_sticky = 2'b00;
    #2;
    check_sticky(2'b00, "R8 cleared");
    send(1'b0, 8'h10, 23'h0, 1'b0, 1'b1, C_UM, "R8 precision only");
    idle(3);
    check_sticky(2'b01, "R8 precision only sticky");
    idle(3);
    check_sticky(2'b01, "R8 hold");
    // clear meets a new pulse in the same cycle
    exp_sticky = 2'b00;
    send(1'b1, 8'h00, 23'h1, 1'b1, 1'b0, C_UM | C_FTZ, "R8 flush before clear");
    @(posedge clk); #1; in_valid = 1'b0; sticky_clr = 1'b1;
    @(posedge clk); #1; sticky_clr = 1'b0;
    idle(2);
    check_sticky(2'b11, "R8 clear with pulse keeps pulse");

    // Back-to-back random stream through the scoreboard
    for (int i = 0; i < 60; i++) begin
      logic [31:0] c;
      c = $urandom;
      send(1'($urandom), 8'($urandom), 23'($urandom), 1'($urandom), 1'($urandom), c,
           "R2 R3 R5 R6 stream");
      if (($urandom % 5) == 0) idle(1);
    end
    idle(4);
    check_sticky(exp_sticky | 2'b11 & exp_sticky, "R8 after stream");

    checks++;
    if (q.size() != 0) begin
      errors++;
      $display("FAIL R2 outstanding results actual=%0d expected=0", q.size());
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule